// File: doc/BRIEF.md
# Selective Status Flag Transfer Unit

This block moves chosen floating-point status flags into the integer CPU status bits, so that the ordinary conditional branches can act on the result of a floating-point compare or arithmetic operation. A transfer is issued by a 16-bit instruction word together with an execute strobe. The upper byte of the word identifies the transfer. The lower byte is a select mask, one bit per floating-point flag. Each integer destination bit (OV, N, Z, C, TC) is rewritten only when at least one of its source flags is selected. It then takes the OR of its selected sources. All other destination bits keep their previous value. The whole transfer takes one clock cycle.

A selected latched-underflow or latched-overflow flag is cleared as part of the transfer. The block raises a one-cycle clear request for each such flag, and the floating-point status register applies the clear at the same clock edge. A small hazard tracker watches a strobe that marks the issue of a 2-cycle floating-point operation. When a transfer executes inside that operation's delay slot, the tracker sets a sticky error flag. The transfer itself still completes as usual.

The hazard tracker is a named state machine with two states. `HZ_IDLE` means no multi-cycle result is outstanding. `HZ_SLOT` means the design is inside a delay slot. It has four transitions:
- `T_ISSUE` moves from `HZ_IDLE` to `HZ_SLOT` on an issue strobe.
- `T_REISSUE` stays in `HZ_SLOT` on a new issue strobe and reloads the slot counter.
- `T_COUNT` stays in `HZ_SLOT` while delay slots remain.
- `T_DRAIN` returns from `HZ_SLOT` to `HZ_IDLE` when the last slot has passed.

Top module: `fpflag_xfer`

## Requirements
- R1: A synchronous active-high `rst` clears OV, N, Z, C, TC and `hazard_err_o` to 0, and returns the hazard tracker to `HZ_IDLE`.
- R2: When a transfer selects mask bit 6 (latched underflow) or bit 7 (latched overflow), OV becomes the OR of the selected ones among `fp_flags_i[6]` and `fp_flags_i[7]`. An unselected flag of the pair does not contribute.
- R3: When a transfer selects mask bit 4 (integer negative) or bit 5 (negative), N becomes the OR of the selected ones among `fp_flags_i[4]` and `fp_flags_i[5]`.
- R4: When a transfer selects mask bit 2 (integer zero) or bit 3 (zero), Z becomes the OR of the selected ones among `fp_flags_i[2]` and `fp_flags_i[3]`.
- R5: When a transfer selects mask bit 0 (test flag), both C and TC are loaded from `fp_flags_i[0]`.
- R6: A destination bit none of whose sources is selected keeps its value. Mask bit 1 (integer carry) has no destination and changes nothing.
- R7: During a transfer cycle, `clr_luf_o` equals mask bit 6 and `clr_lvf_o` equals mask bit 7. Both are 0 in every other cycle.
- R8: A transfer happens only when `exec_i` is 1 and `instr_i[15:8]` equals 8'hAD. Otherwise no status bit changes and no clear request is raised.
- R9: The status bits written by a transfer are visible on the outputs after exactly one rising clock edge.
- R10: A transfer executed in the cycle right after `mc_issue_i` was 1 sets `hazard_err_o` at the next edge. A transfer two or more cycles after the last issue does not set it.
- R11: `hazard_err_o` stays 1 until reset. A transfer flagged as a hazard still updates the status bits exactly as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Execute strobe for the instruction on `instr_i` |
| instr_i | input | 16 | Instruction word: key byte in [15:8], select mask in [7:0] |
| fp_flags_i | input | 8 | Floating-point flags at mask positions: 0 test, 1 int carry, 2 int zero, 3 zero, 4 int negative, 5 negative, 6 latched underflow, 7 latched overflow |
| mc_issue_i | input | 1 | A 2-cycle floating-point operation is issued this cycle |
| st_ov_o | output | 1 | Integer overflow status bit |
| st_n_o | output | 1 | Integer negative status bit |
| st_z_o | output | 1 | Integer zero status bit |
| st_c_o | output | 1 | Integer carry status bit |
| st_tc_o | output | 1 | Integer test/control status bit |
| clr_luf_o | output | 1 | Clear request for the latched underflow flag |
| clr_lvf_o | output | 1 | Clear request for the latched overflow flag |
| hazard_err_o | output | 1 | Sticky delay-slot hazard flag |

## Verification
Two functions can fall in the same cycle: the status transfer with its latched-flag clears, and the hazard detection of the delay-slot tracker. The bench provokes this with a directed issue strobe followed at once by a transfer that selects every flag. It then checks that the error flag rises while the status bits and clear requests match the values computed with no hazard present. The random phase repeats this overlap many times, with issue strobes that land next to transfers, transfers that repeat one after another, and mismatched key bytes. Every cycle is checked against a bench model of the merge rules and the one-slot window.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    localparam int MASK_W = 8;
    localparam int KEY_W  = 8;
    localparam int INSN_W = KEY_W + MASK_W;

    // Select-mask bit positions; flags arrive in the same positions.
    localparam int B_TF  = 0;
    localparam int B_CI  = 1;
    localparam int B_ZI  = 2;
    localparam int B_ZF  = 3;
    localparam int B_NI  = 4;
    localparam int B_NF  = 5;
    localparam int B_LUF = 6;
    localparam int B_LVF = 7;

    localparam int ST_W = 5;

    typedef struct packed {
        logic ov;
        logic n;
        logic z;
        logic c;
        logic tc;
    } int_st_t;

    typedef enum logic [0:0] {
        HZ_IDLE = 1'b0,
        HZ_SLOT = 1'b1
    } hz_state_t;

endpackage

// File: rtl/fxu_decode.sv
module fxu_decode
    import fxu_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 8'hAD
) (
    input  logic              exec_i,
    input  logic [INSN_W-1:0] instr_i,
    output logic              xfer_v_o,
    output logic [MASK_W-1:0] mask_o
);

    logic key_hit;

    always_comb begin
        key_hit  = (instr_i[INSN_W-1 -: KEY_W] == KEY);
        xfer_v_o = exec_i && key_hit;
        mask_o   = instr_i[MASK_W-1:0];
    end

endmodule

// File: rtl/fxu_merge.sv
module fxu_merge
    import fxu_pkg::*;
(
    input  logic              xfer_v_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [MASK_W-1:0] flags_i,
    input  int_st_t           cur_i,
    output int_st_t           nxt_o,
    output logic              clr_luf_o,
    output logic              clr_lvf_o
);

    // Selected flags only; an unselected flag never reaches an OR.
    logic [MASK_W-1:0] gated;
    logic              hit_ov, hit_n, hit_z, hit_t;
    logic              unused_ci;

    assign unused_ci = ^{mask_i[B_CI], flags_i[B_CI]};

    genvar g;
    generate
        for (g = 0; g < MASK_W; g++) begin : g_gate
            assign gated[g] = mask_i[g] & flags_i[g];
        end
    endgenerate

    always_comb begin
        hit_ov = xfer_v_i && (mask_i[B_LUF] || mask_i[B_LVF]);
        hit_n  = xfer_v_i && (mask_i[B_NI]  || mask_i[B_NF]);
        hit_z  = xfer_v_i && (mask_i[B_ZI]  || mask_i[B_ZF]);
        hit_t  = xfer_v_i &&  mask_i[B_TF];

        nxt_o = cur_i;
        if (hit_ov) nxt_o.ov = gated[B_LUF] | gated[B_LVF];
        if (hit_n)  nxt_o.n  = gated[B_NI]  | gated[B_NF];
        if (hit_z)  nxt_o.z  = gated[B_ZI]  | gated[B_ZF];
        if (hit_t) begin
            nxt_o.c  = gated[B_TF];
            nxt_o.tc = gated[B_TF];
        end

        clr_luf_o = xfer_v_i && mask_i[B_LUF];
        clr_lvf_o = xfer_v_i && mask_i[B_LVF];
    end

endmodule

// File: rtl/fxu_hazard.sv
module fxu_hazard
    import fxu_pkg::*;
#(
    parameter int SLOTS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic xfer_v_i,
    output logic err_o
);

    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SLOTS - 1);

    hz_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_q, err_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HZ_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        unique case (state_q)
            HZ_IDLE: begin
                if (issue_i) begin          // T_ISSUE
                    state_d = HZ_SLOT;
                    cnt_d   = CNT_LOAD;
                end
            end
            HZ_SLOT: begin
                if (xfer_v_i) err_d = 1'b1;
                if (issue_i) begin          // T_REISSUE
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin // T_DRAIN
                    state_d = HZ_IDLE;
                end else begin              // T_COUNT
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = HZ_IDLE;
        endcase
    end

    assign err_o = err_q;

endmodule

// File: rtl/fpflag_xfer.sv
module fpflag_xfer
    import fxu_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY         = 8'hAD,
    parameter int               DELAY_SLOTS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [MASK_W-1:0] fp_flags_i,
    input  logic              mc_issue_i,
    output logic              st_ov_o,
    output logic              st_n_o,
    output logic              st_z_o,
    output logic              st_c_o,
    output logic              st_tc_o,
    output logic              clr_luf_o,
    output logic              clr_lvf_o,
    output logic              hazard_err_o
);

    logic              xfer_v;
    logic [MASK_W-1:0] mask;
    int_st_t           st_q, st_d;

    fxu_decode #(.KEY(KEY)) u_dec (
        .exec_i   (exec_i),
        .instr_i  (instr_i),
        .xfer_v_o (xfer_v),
        .mask_o   (mask)
    );

    fxu_merge u_mrg (
        .xfer_v_i  (xfer_v),
        .mask_i    (mask),
        .flags_i   (fp_flags_i),
        .cur_i     (st_q),
        .nxt_o     (st_d),
        .clr_luf_o (clr_luf_o),
        .clr_lvf_o (clr_lvf_o)
    );

    fxu_hazard #(.SLOTS(DELAY_SLOTS)) u_hz (
        .clk      (clk),
        .rst      (rst),
        .issue_i  (mc_issue_i),
        .xfer_v_i (xfer_v),
        .err_o    (hazard_err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_ov_o = st_q.ov;
    assign st_n_o  = st_q.n;
    assign st_z_o  = st_q.z;
    assign st_c_o  = st_q.c;
    assign st_tc_o = st_q.tc;

endmodule

// File: rtl/fxu_check.sv
module fxu_check (
    input logic        clk,
    input logic        rst,
    input logic        exec_i,
    input logic [15:0] instr_i,
    input logic [7:0]  fp_flags_i,
    input logic        st_ov_o,
    input logic        st_n_o,
    input logic        st_z_o,
    input logic        st_c_o,
    input logic        st_tc_o,
    input logic        clr_luf_o,
    input logic        clr_lvf_o,
    input logic        hazard_err_o
);

    logic go;
    assign go = exec_i && (instr_i[15:8] == 8'hAD);

    a_r8_no_clear_idle: assert property (@(posedge clk) disable iff (rst)
        !exec_i |-> (!clr_luf_o && !clr_lvf_o));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> $stable({st_ov_o, st_n_o, st_z_o, st_c_o, st_tc_o}));

    a_r5_c_tc_pair: assert property (@(posedge clk) disable iff (rst)
        (go && instr_i[0]) |=> (st_c_o == st_tc_o));

    a_r6_keep_c: assert property (@(posedge clk) disable iff (rst)
        (go && !instr_i[0]) |=> ($stable(st_c_o) && $stable(st_tc_o)));

    a_r2_ov_set: assert property (@(posedge clk) disable iff (rst)
        (go && instr_i[7] && fp_flags_i[7]) |=> st_ov_o);

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        hazard_err_o |=> hazard_err_o);

endmodule

bind fpflag_xfer fxu_check chk_i (
    .clk          (clk),
    .rst          (rst),
    .exec_i       (exec_i),
    .instr_i      (instr_i),
    .fp_flags_i   (fp_flags_i),
    .st_ov_o      (st_ov_o),
    .st_n_o       (st_n_o),
    .st_z_o       (st_z_o),
    .st_c_o       (st_c_o),
    .st_tc_o      (st_tc_o),
    .clr_luf_o    (clr_luf_o),
    .clr_lvf_o    (clr_lvf_o),
    .hazard_err_o (hazard_err_o)
);

// File: tb/fpflag_xfer_tb_top.sv
module fpflag_xfer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_i;
    logic [15:0] instr_i;
    logic [7:0]  fp_flags_i;
    logic        mc_issue_i;
    logic        st_ov_o, st_n_o, st_z_o, st_c_o, st_tc_o;
    logic        clr_luf_o, clr_lvf_o, hazard_err_o;

    int checks = 0;
    int fails  = 0;

    // Model state: {ov, n, z, c, tc}
    logic [4:0] m_st;
    logic       m_err;
    logic       m_prev_issue;

    always #2 clk = ~clk;

    fpflag_xfer dut_i (
        .clk(clk), .rst(rst), .exec_i(exec_i), .instr_i(instr_i),
        .fp_flags_i(fp_flags_i), .mc_issue_i(mc_issue_i),
        .st_ov_o(st_ov_o), .st_n_o(st_n_o), .st_z_o(st_z_o),
        .st_c_o(st_c_o), .st_tc_o(st_tc_o),
        .clr_luf_o(clr_luf_o), .clr_lvf_o(clr_lvf_o),
        .hazard_err_o(hazard_err_o)
    );

    function automatic logic [4:0] merge(input logic [4:0] s,
                                         input logic [7:0] m,
                                         input logic [7:0] f);
        logic [4:0] r;
        logic [7:0] g;
        r = s;
        g = m & f;
        if (m[6] || m[7]) r[4] = g[6] | g[7];
        if (m[4] || m[5]) r[3] = g[4] | g[5];
        if (m[2] || m[3]) r[2] = g[2] | g[3];
        if (m[0]) begin
            r[1] = g[0];
            r[0] = g[0];
        end
        return r;
    endfunction

    function automatic logic [4:0] dut_st();
        return {st_ov_o, st_n_o, st_z_o, st_c_o, st_tc_o};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Called right after a falling edge.
    task automatic step(input logic ex, input logic [15:0] ins,
                        input logic [7:0] fl, input logic iss,
                        input string tag);
        logic v;
        exec_i = ex; instr_i = ins; fp_flags_i = fl; mc_issue_i = iss;
        #1;
        v = ex && (ins[15:8] == 8'hAD);
        check(tag, "clears", {6'b0, clr_lvf_o, clr_luf_o},
              {6'b0, v && ins[7], v && ins[6]});
        if (v && m_prev_issue) m_err = 1'b1;
        m_prev_issue = iss;
        if (v) m_st = merge(m_st, ins[7:0], fl);
        @(posedge clk);
        @(negedge clk);
        check(tag, "status", {3'b0, dut_st()}, {3'b0, m_st});
        check(tag, "hazard", {7'b0, hazard_err_o}, {7'b0, m_err});
    endtask

    task automatic do_reset();
        rst = 1'b1; exec_i = 0; instr_i = 0; fp_flags_i = 0; mc_issue_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = '0; m_err = 0; m_prev_issue = 0;
        check("R1", "reset status", {3'b0, dut_st()}, 8'd0);
        check("R1", "reset hazard", {7'b0, hazard_err_o}, 8'd0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [15:0] ins;
        seed = 32'd12345;
        void'($urandom(seed));
        do_reset();

        // R2 R3 R4 R5 R7 R9: select everything with all flags set.
        step(1, 16'hADFF, 8'hFF, 0, "R9");
        // R5 R6: only test flag, cleared -> C,TC drop, others keep.
        step(1, 16'hAD01, 8'h00, 0, "R5");
        // R6: integer-carry bit alone changes nothing.
        step(1, 16'hAD02, 8'hFF, 0, "R6");
        // R2: only latched-underflow selected, overflow flag set -> OV 0.
        step(1, 16'hAD40, 8'h80, 0, "R2");
        step(1, 16'hAD80, 8'h80, 0, "R2");
        // R3: only integer-negative selected while negative set -> N 0.
        step(1, 16'hAD10, 8'h20, 0, "R3");
        // R4: integer-zero selected and set -> Z 1.
        step(1, 16'hAD04, 8'h04, 0, "R4");
        // R7: overflow clear only.
        step(1, 16'hAD80, 8'h00, 0, "R7");
        // R8: wrong key, and no strobe.
        step(1, 16'hACFF, 8'h00, 0, "R8");
        step(0, 16'hADFF, 8'h00, 0, "R8");
        // R10: transfer two cycles after issue -> no error.
        step(0, 16'h0000, 8'h00, 1, "R10");
        step(0, 16'h0000, 8'h00, 0, "R10");
        step(1, 16'hADFF, 8'h55, 0, "R10");
        // R10 R11: transfer in the delay slot -> error, result still applied.
        step(0, 16'h0000, 8'h00, 1, "R10");
        step(1, 16'hADFF, 8'hAA, 0, "R11");
        step(0, 16'h0000, 8'h00, 0, "R11");
        step(1, 16'hAD3C, 8'h00, 0, "R11");

        do_reset();
        for (int i = 0; i < 600; i++) begin
            ins[15:8] = ($urandom % 8 == 0) ? 8'($urandom) : 8'hAD;
            ins[7:0]  = 8'($urandom);
            step(($urandom % 3) != 0, ins, 8'($urandom),
                 ($urandom % 4) == 0, "R2/R3/R4/R5/R6/R7/R8/R10");
        end
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule